// File: doc/BRIEF.md
# Switching-Synchronous Current Averaging Filter

This block turns a stream of 10-bit inductor-current conversions into one average per PWM switching period. A one-cycle frame pulse from the PWM timing marks the start of each period. From that pulse the block issues a fixed train of sixteen conversion-start strobes, evenly spaced by a programmable number of clock cycles, so that the sampling is locked to the switching period. The frame pulse also clears the accumulator.

Each data-valid returned by the converter adds its sample to a 14-bit running sum. The sixteenth accepted sample completes the window. The block then shifts the sum right by four bits to form the average and raises a one-cycle result strobe for the downstream current compensator. The sample spacing is chosen so that the whole window fits within one period, which places the result just ahead of the next switching pulse.

If a period closes with fewer than sixteen samples, the block produces no result for it and keeps the last good average on its output. It also raises a short-frame flag, which holds until the next frame pulse.

Top module: `frame_avg_filter`

## Requirements
- R1: Out of reset, `avg_out` is 0, `avg_valid` is 0, `short_frame_err` is 0, and `conv_start` stays low until the first `pwm_frame` pulse.
- R2: After each `pwm_frame` pulse the block issues exactly 16 one-cycle `conv_start` strobes. The first comes in the cycle right after the pulse, and each later strobe comes CONV_DIV cycles after the one before it.
- R3: The average is the sum of the first 16 samples accepted in a frame, shifted right by 4 and truncated to 10 bits. An all-1023 frame gives 1023 with no wrap.
- R4: `avg_valid` is high for exactly one cycle, namely the cycle after the 16th accepted `samp_valid` of the frame.
- R5: A `pwm_frame` pulse clears the running sum and count. A `samp_valid` that coincides with the pulse is discarded, and no sample carries over from one period to the next.
- R6: A `samp_valid` after the 16th accepted sample of a frame is ignored, and so is any `samp_valid` before the first `pwm_frame` after reset.
- R7: In the cycle after each `pwm_frame` pulse, `short_frame_err` shows whether the period just closed accepted fewer than 16 samples. It shows 0 for the first pulse after reset, and it changes at no other time.
- R8: `avg_out` changes only together with `avg_valid`. A period with fewer than 16 samples gives no `avg_valid` and leaves `avg_out` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_frame | input | 1 | One-cycle pulse at the start of each switching period |
| conv_start | output | 1 | Converter start strobe |
| samp_valid | input | 1 | Converter data-valid |
| samp_data | input | SAMPLE_W | Converter sample |
| avg_out | output | SAMPLE_W | Latest period average |
| avg_valid | output | 1 | One-cycle strobe for a new average |
| short_frame_err | output | 1 | The last period closed with fewer than 16 samples |

## Verification
The bench goes after the corners where the window's edges are most easily misplaced. If a design leaked state across the boundary, the discarded sample that coincides with each frame pulse, or the remains of a short period, would show up in the next average. If it did not close its window, the extra valids sent after the sixteenth sample would shift the result or cause a second strobe. An all-maximum frame exposes an accumulator that is too narrow, because its average wraps. A sweep over hundreds of sample patterns catches a rounding or shift error in the low bits. Short frames placed between full ones show whether the flag and the held average behave: a wrong design misses the flag, clears the average, or strobes for an incomplete window.

// File: rtl/fav_pkg.sv
// Shared sizing helpers for the frame-locked averaging filter.
package fav_pkg;
    // Width of a sum of 2**lg samples of sw bits without overflow.
    function automatic int sum_width(input int sw, input int lg);
        return sw + lg;
    endfunction
    // Width of a counter able to hold the value n.
    function automatic int count_width(input int n);
        return (n > 1) ? $clog2(n + 1) : 1;
    endfunction
endpackage

// File: rtl/fav_strobe_gen.sv
// Conversion-strobe sequencer: each frame pulse launches NSAMP strobes,
// the first one cycle after the pulse and then every DIV cycles.
// Assumes DIV*NSAMP fits inside one switching period.
module fav_strobe_gen #(
    parameter int NSAMP = 16,
    parameter int DIV   = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    output logic start_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int CW = fav_pkg::count_width(NSAMP);

    logic          running_q;
    logic [DW-1:0] div_q;
    logic [CW-1:0] issued_q;

    // Strobe when the spacing counter wraps and strobes remain
    assign start_o = running_q && (div_q == '0) && (issued_q != CW'(NSAMP));

    // Restart the schedule on a frame pulse, otherwise pace and count strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            div_q     <= '0;
            issued_q  <= '0;
        end else if (frame_i) begin
            running_q <= 1'b1;
            div_q     <= '0;
            issued_q  <= '0;
        end else if (running_q) begin
            div_q <= (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
            if (start_o) issued_q <= issued_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2
            strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                start_o |=> !start_o);
        end
    endgenerate
endmodule

// File: rtl/fav_accum.sv
// Window accumulator: it sums the first 2**LG valid samples after a frame
// pulse and reports completion together with the final sum. A valid that
// arrives with the frame pulse, or before the first pulse, is dropped.
module fav_accum #(
    parameter int SW = 10,
    parameter int LG = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   frame_i,
    input  logic                                   vld_i,
    input  logic [SW-1:0]                          data_i,
    output logic                                   done_o,
    output logic [fav_pkg::sum_width(SW,LG)-1:0]   sum_o,
    output logic                                   active_o,
    output logic                                   full_o
);
    localparam int N  = 1 << LG;
    localparam int AW = fav_pkg::sum_width(SW, LG);
    localparam int CW = fav_pkg::count_width(N);

    logic [AW-1:0] acc_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic          take;

    // Accept a sample only inside an open window that is not yet full
    assign take     = active_q && vld_i && !frame_i && (cnt_q != CW'(N));
    assign sum_o    = acc_q + AW'(data_i);
    assign done_o   = take && (cnt_q == CW'(N - 1));
    assign active_o = active_q;
    assign full_o   = (cnt_q == CW'(N));

    // Clear at each frame pulse, accumulate accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (frame_i) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (take) begin
            acc_q <= sum_o;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i |=> (acc_q == '0));
endmodule

// File: rtl/fav_result.sv
// Result stage: it registers the shifted average and its strobe when a
// window completes, and updates the short-frame flag at each frame pulse.
module fav_result #(
    parameter int SW = 10,
    parameter int LG = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 frame_i,
    input  logic                                 done_i,
    input  logic [fav_pkg::sum_width(SW,LG)-1:0] sum_i,
    input  logic                                 active_i,
    input  logic                                 full_i,
    output logic [SW-1:0]                        avg_o,
    output logic                                 avg_vld_o,
    output logic                                 err_o
);
    localparam int AW = fav_pkg::sum_width(SW, LG);

    // Capture the truncated average on window completion, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_o     <= '0;
            avg_vld_o <= 1'b0;
        end else begin
            avg_vld_o <= done_i;
            if (done_i) avg_o <= sum_i[AW-1:LG];
        end
    end

    // Judge the period that just closed when the next one opens
    always_ff @(posedge clk) begin
        if (!rst_n)       err_o <= 1'b0;
        else if (frame_i) err_o <= active_i && !full_i;
    end

    // R4
    avg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld_o |=> !avg_vld_o);
    // R8
    avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_o != $past(avg_o)) |-> avg_vld_o);
    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(frame_i));
    // R7
    err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(frame_i));
endmodule

// File: rtl/frame_avg_filter.sv
// Switching-synchronous current averaging filter: it launches 2**LOG2_SAMPLES
// conversions per PWM frame and delivers their truncated mean with a
// one-cycle strobe. A frame that closes with a short count raises the flag.
module frame_avg_filter #(
    parameter int SAMPLE_W     = 10,
    parameter int LOG2_SAMPLES = 4,
    parameter int CONV_DIV     = 500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwm_frame,
    output logic                conv_start,
    input  logic                samp_valid,
    input  logic [SAMPLE_W-1:0] samp_data,
    output logic [SAMPLE_W-1:0] avg_out,
    output logic                avg_valid,
    output logic                short_frame_err
);
    localparam int NSAMP = 1 << LOG2_SAMPLES;
    localparam int AW    = fav_pkg::sum_width(SAMPLE_W, LOG2_SAMPLES);

    logic          win_done;
    logic [AW-1:0] win_sum;
    logic          win_active;
    logic          win_full;

    fav_strobe_gen #(.NSAMP(NSAMP), .DIV(CONV_DIV)) u_strobe (
        .clk(clk), .rst_n(rst_n), .frame_i(pwm_frame), .start_o(conv_start)
    );

    fav_accum #(.SW(SAMPLE_W), .LG(LOG2_SAMPLES)) u_accum (
        .clk(clk), .rst_n(rst_n), .frame_i(pwm_frame), .vld_i(samp_valid),
        .data_i(samp_data), .done_o(win_done), .sum_o(win_sum),
        .active_o(win_active), .full_o(win_full)
    );

    fav_result #(.SW(SAMPLE_W), .LG(LOG2_SAMPLES)) u_result (
        .clk(clk), .rst_n(rst_n), .frame_i(pwm_frame), .done_i(win_done),
        .sum_i(win_sum), .active_i(win_active), .full_i(win_full),
        .avg_o(avg_out), .avg_vld_o(avg_valid), .err_o(short_frame_err)
    );

    // R4
    avg_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> $past(samp_valid));
    // R1
    no_strobe_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_active) |-> !conv_start);
endmodule

// File: tb/frame_avg_filter_test.sv
module frame_avg_filter_test;
    localparam int DIV   = 4;
    localparam int NS    = 16;
    localparam int FRAME = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_frame = 1'b0;
    logic       conv_start;
    logic       samp_valid = 1'b0;
    logic [9:0] samp_data = '0;
    logic [9:0] avg_out;
    logic       avg_valid;
    logic       short_frame_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int prev_avg   = 0;
    int prev_state = -1;   // -1 no frame yet, 0 full, 1 short

    always #2 clk = ~clk;

    frame_avg_filter #(.SAMPLE_W(10), .LOG2_SAMPLES(4), .CONV_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .pwm_frame(pwm_frame), .conv_start(conv_start),
        .samp_valid(samp_valid), .samp_data(samp_data), .avg_out(avg_out),
        .avg_valid(avg_valid), .short_frame_err(short_frame_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gen(input int kind, input int seed, input int k);
        if (kind == 1) return 1023;
        if (kind == 2) return 0;
        return (seed * 131 + k * 37 + k * k * (seed % 13)) % 1024;
    endfunction

    // One frame: pulse (with a colliding valid), nval valid samples, nextra late valids
    task automatic run_frame(input int kind, input int seed, input int nval, input int nextra);
        int strobes = 0, last_strobe = -1, delivered = 0, sum = 0;
        int nvld = 0, vld_at = -1, last_vld_cyc = -1;
        bit pend = 1'b0;
        @(negedge clk);
        pwm_frame = 1'b1; samp_valid = 1'b1; samp_data = 10'd1023;   // R5 discarded
        @(negedge clk);
        pwm_frame = 1'b0;
        // R7 flag reflects the period just closed
        chk(short_frame_err == (prev_state == 1), "R7", int'(short_frame_err), int'(prev_state == 1));
        for (int i = 0; i < FRAME; i++) begin
            samp_valid = 1'b0;
            if (pend && delivered < nval) begin
                samp_valid = 1'b1;
                samp_data  = 10'(gen(kind, seed, delivered));
                sum += gen(kind, seed, delivered);
                delivered++;
                if (delivered == NS) last_vld_cyc = i;
            end else if (i >= 64 && i < 64 + nextra) begin
                samp_valid = 1'b1;                       // R6 late valids
                samp_data  = 10'd1023;
            end
            pend = conv_start;
            if (conv_start) begin
                if (strobes == 0) chk(i == 0, "R2", i, 0);
                else chk(i - last_strobe == DIV, "R2", i - last_strobe, DIV);
                strobes++;
                last_strobe = i;
            end
            if (avg_valid) begin
                nvld++;
                vld_at = i;
            end
            @(negedge clk);
        end
        samp_valid = 1'b0;
        chk(strobes == NS, "R2", strobes, NS);
        if (nval >= NS) begin
            chk(nvld == 1, "R4", nvld, 1);
            chk(vld_at == last_vld_cyc + 1, "R4", vld_at, last_vld_cyc + 1);
            chk(int'(avg_out) == sum / NS, "R3", int'(avg_out), sum / NS);
            prev_avg = sum / NS;
            prev_state = 0;
        end else begin
            chk(nvld == 0, "R8", nvld, 0);
            chk(int'(avg_out) == prev_avg, "R8", int'(avg_out), prev_avg);
            prev_state = 1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            // R1 quiet outputs before any frame
            chk(!conv_start && !avg_valid && avg_out == 0 && !short_frame_err, "R1",
                int'({conv_start, avg_valid, short_frame_err}) + int'(avg_out), 0);
            samp_valid = (i > 1);
            samp_data  = 10'd1023;
            @(negedge clk);
        end
        samp_valid = 1'b0;
        @(negedge clk);
        chk(!avg_valid && avg_out == 0, "R6", int'(avg_out), 0);
        run_frame(1, 0, 16, 4);          // R3 all-max, no wrap
        run_frame(2, 0, 16, 0);          // all zero
        run_frame(0, 5, 9, 0);           // short frame, R8 hold
        run_frame(0, 6, 16, 3);          // R7 flag set then cleared next
        run_frame(0, 7, 0, 0);           // empty frame
        run_frame(0, 8, 15, 0);          // one short
        run_frame(1, 0, 16, 0);
        for (int s = 0; s < 600; s++) begin
            if (s % 7 == 3) run_frame(0, s, s % 16, 0);
            else            run_frame(0, s, 16, s % 5);
        end
        run_frame(0, 1, 16, 0);          // flush last flag
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule